// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block sits between instruction storage and the decode stage. It fetches consecutive big-endian halfwords from storage, keeps them in a small shift buffer, and puts together whole instructions of one, two or three halfwords (2, 4 or 6 bytes). The length comes from the two top bits of the opcode byte, so the first halfword alone decides how many halfwords are needed. Each instruction goes to decode with its byte length and its start address. The decode stage can stall it with a ready signal.

Storage is read through a request/acknowledge pair. The block requests the next halfword whenever its buffer has a free slot. The storage answers in the cycle it acknowledges. A redirect empties the buffer and restarts both fetch and issue at a new address. An odd redirect address is a specification error: the block raises a flag and goes quiet until the next redirect.

Top module: `ifa_aligner`

## Requirements
- R1: The instruction length in bytes comes from opcode bits [15:14] of the first halfword: 00 gives 2, 01 and 10 give 4, and 11 gives 6. So an instruction starting with byte 0xD2 is 6 bytes long.
- R2: An instruction is offered only when all of its halfwords are buffered. `ins_data` holds the lowest-addressed halfword in bits [47:32], the next in [31:16] and the third in [15:0]. Bits past the instruction's length are zero.
- R3: The buffer never holds more than `DEPTH` halfwords. `fetch_req` is high exactly when no error is pending and fewer than `DEPTH` halfwords are buffered.
- R4: A halfword is taken in any cycle where `fetch_req` and `fetch_ack` are both high and there is no redirect. Each taken halfword advances `fetch_addr` by 2.
- R5: The first `ins_addr` after a redirect is the redirect address. Each issue (`ins_valid` and `ins_ready` both high) advances it by the issued length.
- R6: While `ins_valid` is high and `ins_ready` is low, with no redirect, `ins_valid`, `ins_data`, `ins_len` and `ins_addr` hold their values into the next cycle.
- R7: A redirect takes priority. One cycle later the buffer is empty and `fetch_addr` equals the redirect address. An issue handshake in the redirect cycle still counts as issued. A halfword fetched in the redirect cycle is discarded.
- R8: A redirect to an address with bit 0 set raises `spec_err` from the next cycle. While `spec_err` is high, `fetch_req` and `ins_valid` stay low. The flag clears on the next redirect to an even address.
- R9: After reset, `ins_valid` and `spec_err` are low, `fetch_req` is high and `fetch_addr` equals `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Restart fetch at `redir_addr` |
| redir_addr | input | AW | New instruction address |
| fetch_req | output | 1 | Request for the halfword at `fetch_addr` |
| fetch_addr | output | AW | Byte address of the requested halfword |
| fetch_ack | input | 1 | Storage supplies `fetch_data` this cycle |
| fetch_data | input | 16 | Halfword read from storage |
| ins_valid | output | 1 | A complete instruction is offered |
| ins_ready | input | 1 | Decode accepts the offered instruction |
| ins_data | output | 48 | Instruction, left-justified |
| ins_len | output | 3 | Length in bytes: 2, 4 or 6 |
| ins_addr | output | AW | Start address of the instruction |
| spec_err | output | 1 | Odd instruction address seen |

## Verification
All outputs are decoded from registered state, so every response to inputs applied in one cycle shows up one clock edge later. The bench drives inputs at the falling edge. It compares every output against the model's next state at the following falling edge. That covers the first valid instruction after a refill, the new `fetch_addr` after a redirect, the rise of `spec_err` one cycle after an odd redirect, and the held values during a stall. `ins_valid` rises on the edge that stores the last halfword an instruction needs, never earlier.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

    typedef logic [15:0] hw_t;

    // halfwords occupied by an instruction, from the two top opcode bits
    function automatic logic [1:0] hw_count(input logic [1:0] op_hi);
        case (op_hi)
            2'b00:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/ifa_len_decode.sv
module ifa_len_decode
    import ifa_pkg::*;
(
    input  hw_t        head,
    output logic [1:0] n_hw,
    output logic [2:0] n_bytes
);
    always_comb begin
        n_hw    = hw_count(head[15:14]);
        n_bytes = {n_hw, 1'b0};
    end

    always_comb begin
        assert (n_hw != 2'd0) else $error("p_len_nonzero_r1");
    end
endmodule

// File: rtl/ifa_hw_buffer.sv
module ifa_hw_buffer
    import ifa_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  hw_t           push_hw,
    input  logic [1:0]    pop_n,
    output logic [CW-1:0] cnt,
    output hw_t           win0,
    output hw_t           win1,
    output hw_t           win2
);
    typedef struct packed {
        logic [DEPTH-1:0][15:0] slot;
        logic [CW-1:0]          cnt;
    } buf_s;

    buf_s buf_d, buf_q;

    always_comb begin
        int wr;
        buf_d = buf_q;
        wr    = int'(buf_q.cnt) - int'(pop_n);
        if (flush) begin
            buf_d.slot = '0;
            buf_d.cnt  = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i + int'(pop_n) < DEPTH)
                    buf_d.slot[i] = buf_q.slot[i + int'(pop_n)];
                else
                    buf_d.slot[i] = '0;
            end
            if (push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i == wr) buf_d.slot[i] = push_hw;
                end
            end
            buf_d.cnt = buf_q.cnt - CW'(pop_n) + CW'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign cnt  = buf_q.cnt;
    assign win0 = buf_q.slot[0];
    assign win1 = buf_q.slot[1];
    assign win2 = buf_q.slot[2];

    // R3: the controller never pushes into a full buffer unless it also pops
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !flush && pop_n == 2'd0 && int'(buf_q.cnt) == DEPTH));

    // R2: the controller never pops more halfwords than are present
    p_pop_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(buf_q.cnt));
endmodule

// File: rtl/ifa_aligner.sv
module ifa_aligner
    import ifa_pkg::*;
#(
    parameter int          AW        = 24,
    parameter int          DEPTH     = 4,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_ack,
    input  logic [15:0]   fetch_data,
    output logic          ins_valid,
    input  logic          ins_ready,
    output logic [47:0]   ins_data,
    output logic [2:0]    ins_len,
    output logic [AW-1:0] ins_addr,
    output logic          spec_err
);
    generate
        if (DEPTH < 3) begin : g_depth_check
            $error("DEPTH must hold a full 6-byte instruction");
        end
    endgenerate

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] faddr;
        logic          err;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [CW-1:0] cnt;
    hw_t           win0, win1, win2;
    logic [1:0]    need_hw;
    logic [2:0]    need_b;
    logic          push;
    logic [1:0]    pop_n;
    logic          have_all;

    ifa_len_decode u_len (
        .head    (win0),
        .n_hw    (need_hw),
        .n_bytes (need_b)
    );

    ifa_hw_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (redir_valid),
        .push    (push),
        .push_hw (fetch_data),
        .pop_n   (pop_n),
        .cnt     (cnt),
        .win0    (win0),
        .win1    (win1),
        .win2    (win2)
    );

    always_comb begin
        have_all  = (cnt != '0) && (int'(cnt) >= int'(need_hw));
        ins_valid = have_all && !ctl_q.err;
        fetch_req = !ctl_q.err && (int'(cnt) < DEPTH);
        push      = fetch_req && fetch_ack && !redir_valid;
        pop_n     = (ins_valid && ins_ready) ? need_hw : 2'd0;

        case (need_hw)
            2'd1:    ins_data = {win0, 32'h0};
            2'd2:    ins_data = {win0, win1, 16'h0};
            default: ins_data = {win0, win1, win2};
        endcase
        ins_len    = need_b;
        ins_addr   = ctl_q.pc;
        fetch_addr = ctl_q.faddr;
        spec_err   = ctl_q.err;

        ctl_d = ctl_q;
        if (redir_valid) begin
            ctl_d.pc    = redir_addr;
            ctl_d.faddr = redir_addr;
            ctl_d.err   = redir_addr[0];
        end else begin
            ctl_d.pc    = ctl_q.pc + AW'({pop_n, 1'b0});
            ctl_d.faddr = ctl_q.faddr + (push ? AW'(2) : AW'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.pc    <= RESET_ADDR;
            ctl_q.faddr <= RESET_ADDR;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (ins_len == 3'd2 || ins_len == 3'd4 || ins_len == 3'd6));

    p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !redir_valid) |=> fetch_addr == $past(fetch_addr) + AW'(2));

    p_issue_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && !redir_valid) |=> ins_addr == $past(ins_addr) + AW'($past(ins_len)));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !redir_valid) |=>
            (ins_valid && $stable(ins_data) && $stable(ins_len) && $stable(ins_addr)));

    p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (fetch_addr == $past(redir_addr) && !ins_valid));

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> (!fetch_req && !ins_valid));
endmodule

// File: tb/tb_ifa_aligner.sv
module tb_ifa_aligner;
    localparam int AW = 24;
    localparam int DEPTH = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          redir_valid = 0;
    logic [AW-1:0] redir_addr = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_ack = 0;
    logic [15:0]   fetch_data;
    logic          ins_valid;
    logic          ins_ready = 0;
    logic [47:0]   ins_data;
    logic [2:0]    ins_len;
    logic [AW-1:0] ins_addr;
    logic          spec_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] memf(input logic [AW-1:0] a);
        logic [15:0] h;
        if (a == 24'h000100) return 16'hD2FF;
        if (a == 24'h000102) return 16'h8001;
        if (a == 24'h000104) return 16'h7000;
        h = a[16:1] * 16'h9E37;
        return h ^ (h >> 5) ^ {a[4:1], 12'h0};
    endfunction

    assign fetch_data = memf(fetch_addr);

    ifa_aligner #(.AW(AW), .DEPTH(DEPTH), .RESET_ADDR('0)) dut (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_data(ins_data), .ins_len(ins_len), .ins_addr(ins_addr),
        .spec_err(spec_err)
    );

    // behavioural reference
    logic [15:0]   mq[$];
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_fa;
    bit            m_err;

    function automatic int need_of(input logic [15:0] h);
        case (h[15:14])
            2'b00:   return 1;
            2'b11:   return 3;
            default: return 2;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_valid();
        return !m_err && mq.size() > 0 && mq.size() >= need_of(mq[0]);
    endfunction

    task automatic compare();
        bit          ev;
        int          n;
        logic [47:0] ed;
        ev = m_valid();
        check(ins_valid == ev, "R2 ins_valid", 64'(ins_valid), 64'(ev));
        check(fetch_req == (!m_err && mq.size() < DEPTH), "R3 fetch_req",
              64'(fetch_req), 64'(!m_err && mq.size() < DEPTH));
        check(fetch_addr == m_fa, "R4 fetch_addr", 64'(fetch_addr), 64'(m_fa));
        check(spec_err == m_err, "R8 spec_err", 64'(spec_err), 64'(m_err));
        if (ev) begin
            n  = need_of(mq[0]);
            ed = {mq[0], (n > 1) ? mq[1] : 16'h0, (n > 2) ? mq[2] : 16'h0};
            check(ins_len == 3'(2 * n), "R1 ins_len", 64'(ins_len), 64'(2 * n));
            check(ins_data == ed, "R2 ins_data", 64'(ins_data), 64'(ed));
            check(ins_addr == m_pc, "R5 ins_addr", 64'(ins_addr), 64'(m_pc));
        end
    endtask

    // one cycle: compare, drive inputs, advance the model, wait for next falling edge
    task automatic cyc(input bit r, input logic [AW-1:0] ra, input bit rdy, input bit ak);
        bit ev, fire_f;
        int n;
        compare();
        redir_valid = r;
        redir_addr  = ra;
        ins_ready   = rdy;
        fetch_ack   = ak;
        ev     = m_valid();
        fire_f = !m_err && mq.size() < DEPTH && ak && !r;
        if (ev && rdy) begin
            n = need_of(mq[0]);
            for (int i = 0; i < n; i++) void'(mq.pop_front());
            m_pc = m_pc + AW'(2 * n);
        end
        if (r) begin
            mq.delete();
            m_pc  = ra;
            m_fa  = ra;
            m_err = ra[0];
        end else if (fire_f) begin
            mq.push_back(memf(m_fa));
            m_fa = m_fa + AW'(2);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [47:0] held_d;
        logic [AW-1:0] held_a;
        mq.delete();
        m_pc = '0; m_fa = '0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        check(!ins_valid && !spec_err && fetch_req && fetch_addr == '0, "R9 reset state",
              {60'h0, ins_valid, spec_err, fetch_req, |fetch_addr}, 64'h2);

        // steady stream, decode always ready
        for (int i = 0; i < 300; i++) cyc(0, '0, 1, 1);
        // random back-pressure and storage stalls
        for (int i = 0; i < 3000; i++) cyc(0, '0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);

        // R1: a 0xD2 opcode is a 6-byte instruction
        cyc(1, 24'h000100, 0, 1);
        while (!ins_valid) cyc(0, '0, 0, 1);
        check(ins_len == 3'd6 && ins_data == 48'hD2FF80017000, "R1 opcode D2 six bytes",
              {13'h0, ins_len, ins_data}, {13'h0, 3'd6, 48'hD2FF80017000});
        // R6: stall holds the offered instruction
        held_d = ins_data; held_a = ins_addr;
        cyc(0, '0, 0, 1);
        check(ins_valid && ins_data == held_d && ins_addr == held_a, "R6 stall hold",
              64'(ins_data), 64'(held_d));
        cyc(0, '0, 1, 1);

        // R7: redirect with a concurrent issue and fetch
        cyc(1, 24'h002468, 1, 1);
        check(fetch_addr == 24'h002468 && !ins_valid, "R7 redirect flush",
              64'(fetch_addr), 64'h002468);

        // R8: odd address
        cyc(1, 24'h000333, 1, 1);
        check(spec_err && !fetch_req && !ins_valid, "R8 odd address error",
              {61'h0, spec_err, fetch_req, ins_valid}, 64'h4);
        for (int i = 0; i < 20; i++) cyc(0, '0, 1, 1);
        cyc(1, 24'h000400, 1, 1);
        check(!spec_err && fetch_req, "R8 error cleared", 64'(spec_err), 64'h0);

        // mixed random redirects
        for (int i = 0; i < 6000; i++) begin
            bit r;
            logic [AW-1:0] ra;
            r  = $urandom_range(0, 40) == 0;
            ra = AW'($urandom_range(0, 24'hFFFF)) & ~AW'(($urandom_range(0, 7) == 0) ? 0 : 1);
            cyc(r, ra, $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0);
        end
        compare();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule